// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Transmitter

This block is the transmit half of a clock-synchronous serial port. Software writes a word into a holding register. The word moves to a separate shift register as soon as that register is free, so software can place the following word while the current frame is still on the line. Frames are 8 to 16 bits long and leave least-significant bit first.

As a master, the block produces the serial clock from a programmable divider of the system clock and drives the data line. As a slave, it drives only the data line. In slave mode it follows an external serial clock, which first passes through a two-flop synchroniser and an edge detector. The idle level of the clock and the edge on which data changes can both be configured.

Three flags report the state of the transmitter: holding register empty, transmit end and overrun. The first two have interrupt enables. An overrun flag, set from outside the block, stops any new frame from starting until software clears it.

Top module: `sync_ser_tx`

## Requirements
- R1: After a synchronous reset, flag_tde=1, flag_tend=0, flag_ovr=0, sdo=0, both interrupt outputs are 0, and sck_out rests at cfg_cpol once reset is released.
- R2: The number of bits per frame is cfg_len when cfg_len is 8..15, 16 when cfg_len=0, and 8 for codes 1..7. Bit 0 is sent first, and word bits above the frame length are never sent.
- R3: A write (wr_vld=1) with tx_en=1 stores wr_data and clears flag_tde and flag_tend at that clock edge. A write with tx_en=0 is ignored: the flags do not change and nothing is sent.
- R4: When the shift register is idle, a word is waiting, tx_en=1 and flag_ovr=0, the word moves to the shift register on the next edge and flag_tde returns to 1. irq_tde equals flag_tde AND ie_tde.
- R5: If a word is waiting when a frame ends, the next frame starts with no idle cycles. In master mode, every two consecutive sck_out transitions within such a burst are cfg_div+1 system clocks apart.
- R6: flag_tend is set when the final bit of a frame completes while flag_tde=1. It stays set until clr_tend or a new accepted write, and it is not set while a word is still pending. irq_tend equals flag_tend AND ie_tend.
- R7: In master mode sck_oe=1, and sck_out rests at cfg_cpol whenever the shifter is idle. A frame of N bits makes exactly 2N sck_out transitions and ends at cfg_cpol.
- R8: Counting the clock transitions of a frame from 1, data changes only on odd transitions, so a receiver samples on even transitions (the moves back to cfg_cpol). With cfg_cpha=0, bit 0 is on sdo from the start of the frame. With cfg_cpha=1, bit 0 appears at transition 1.
- R9: A pulse on ovr_set sets flag_ovr, and a pulse on clr_ovr clears it. While flag_ovr=1 no frame starts and a waiting word stays pending (flag_tde=0).
- R10: In slave mode sck_oe=0 and sck_out stays at cfg_cpol. Transitions of sck_in, after two-flop synchronisation, clock the shifter with the same bit order and phase rules as in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = master (drive clock), 0 = slave |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_len | input | LEN_W | Frame length code |
| cfg_div | input | DIV_W | Master half-period minus one, in system clocks |
| tx_en | input | 1 | Transmit enable |
| ie_tde | input | 1 | Holding-register-empty interrupt enable |
| ie_tend | input | 1 | Transmit-end interrupt enable |
| wr_vld | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Word to transmit |
| clr_tend | input | 1 | Clear transmit-end flag |
| ovr_set | input | 1 | Set overrun flag |
| clr_ovr | input | 1 | Clear overrun flag |
| sck_in | input | 1 | External serial clock (slave) |
| sck_out | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdo | output | 1 | Serial data output |
| flag_tde | output | 1 | Holding register empty |
| flag_tend | output | 1 | Transmit end |
| flag_ovr | output | 1 | Overrun |
| irq_tde | output | 1 | Holding-register-empty interrupt request |
| irq_tend | output | 1 | Transmit-end interrupt request |

## Verification
Some rules are checked by assertions on every cycle. The clock must rest at its idle level while the shifter is idle. Data must hold still across every even transition. The empty flag must return after each load. A reload at the end of a frame must keep the shifter busy. Transmit end may only rise while the holding register is empty. Overrun must keep an idle shifter idle.

Other behaviour can only be shown by the bench's scenarios, which compare the serial stream bit by bit against the written words. These include bit order, frame length decoding, the two phases, gapless back-to-back frames, slave operation from an external clock, writes ignored while disabled, and the flag and interrupt sequencing.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef struct packed {
    logic master;
    logic cpha;
    logic cpol;
  } sst_mode_t;

  // Length code to bit count: 0 selects the maximum, small codes clamp up.
  function automatic int sst_frame_bits(input int code, input int min_bits, input int max_bits);
    if (code == 0)        return max_bits;
    if (code < min_bits)  return min_bits;
    if (code > max_bits)  return max_bits;
    return code;
  endfunction

endpackage

// File: rtl/sst_edge_gen.sv
module sst_edge_gen #(
  parameter int DIV_W   = 8,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  logic             busy,
  input  logic [DIV_W-1:0] div,
  input  logic             sck_in,
  output logic             tick
);
  localparam int PIPE_N = SYNC_N + 1;

  logic [DIV_W-1:0]  cnt;
  logic [PIPE_N-1:0] pipe;
  logic              m_tick, s_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pipe <= '0;
    end else begin
      pipe <= {pipe[PIPE_N-2:0], sck_in};
      if (!busy || !master)  cnt <= '0;
      else if (cnt == div)   cnt <= '0;
      else                   cnt <= cnt + 1'b1;
    end
  end

  assign m_tick = (cnt == div);
  assign s_tick = pipe[PIPE_N-1] ^ pipe[PIPE_N-2];
  assign tick   = busy & (master ? m_tick : s_tick);

endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NB_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  sst_mode_t         mode,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [NB_W-1:0]   ld_bits,
  input  logic              tick,
  output logic              busy,
  output logic              frame_end,
  output logic              sdo,
  output logic              sck_out
);
  localparam int CNT_W = NB_W + 1;

  logic [DATA_W-1:0] sr;
  logic [NB_W-1:0]   nbits;
  logic [CNT_W-1:0]  ecnt;
  logic [DATA_W-1:0] shifted;
  logic              last;

  assign last      = (ecnt == CNT_W'({nbits, 1'b0} - 1'b1));
  assign frame_end = busy & tick & last;
  assign shifted   = sr >> ecnt[CNT_W-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      nbits   <= '0;
      ecnt    <= '0;
      busy    <= 1'b0;
      sdo     <= 1'b0;
      sck_out <= 1'b1;
    end else if (load) begin
      sr      <= ld_data;
      nbits   <= ld_bits;
      ecnt    <= '0;
      busy    <= 1'b1;
      sck_out <= mode.cpol;
      if (!mode.cpha) sdo <= ld_data[0];
    end else if (busy && tick) begin
      if (mode.master) sck_out <= ~sck_out;
      if (!ecnt[0] && !(ecnt == '0 && !mode.cpha)) sdo <= shifted[0];
      if (last) begin
        busy <= 1'b0;
        ecnt <= '0;
      end else begin
        ecnt <= ecnt + 1'b1;
      end
    end else if (!busy) begin
      sck_out <= mode.cpol;
    end
  end

  p_sck_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (sck_out == $past(mode.cpol)));

  p_sdo_even_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && tick && ecnt[0] && !last) |=> $stable(sdo));

endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import sst_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LEN_W    = 4,
  parameter int MIN_BITS = 8,
  parameter int DIV_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_master,
  input  logic              cfg_cpha,
  input  logic              cfg_cpol,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tx_en,
  input  logic              ie_tde,
  input  logic              ie_tend,
  input  logic              wr_vld,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_tend,
  input  logic              ovr_set,
  input  logic              clr_ovr,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  output logic              sdo,
  output logic              flag_tde,
  output logic              flag_tend,
  output logic              flag_ovr,
  output logic              irq_tde,
  output logic              irq_tend
);
  localparam int NB_W = $clog2(DATA_W + 1);

  sst_mode_t         mode;
  logic [DATA_W-1:0] hold;
  logic [NB_W-1:0]   bits_dec;
  logic              wr_ok, load, busy, frame_end, tick;

  assign mode     = '{master: cfg_master, cpha: cfg_cpha, cpol: cfg_cpol};
  assign bits_dec = NB_W'(sst_frame_bits(int'(cfg_len), MIN_BITS, DATA_W));
  assign wr_ok    = wr_vld & tx_en;
  assign load     = (!busy || frame_end) && !flag_tde && tx_en && !flag_ovr;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold      <= '0;
      flag_tde  <= 1'b1;
      flag_tend <= 1'b0;
      flag_ovr  <= 1'b0;
    end else begin
      if (wr_ok) hold <= wr_data;

      if (wr_ok)     flag_tde <= 1'b0;
      else if (load) flag_tde <= 1'b1;

      if (wr_ok || clr_tend)            flag_tend <= 1'b0;
      else if (frame_end && flag_tde)   flag_tend <= 1'b1;

      if (ovr_set)      flag_ovr <= 1'b1;
      else if (clr_ovr) flag_ovr <= 1'b0;
    end
  end

  assign irq_tde  = flag_tde & ie_tde;
  assign irq_tend = flag_tend & ie_tend;
  assign sck_oe   = cfg_master;

  sst_edge_gen #(.DIV_W(DIV_W), .SYNC_N(2)) i_edge (
    .clk    (clk),
    .rst    (rst),
    .master (cfg_master),
    .busy   (busy),
    .div    (cfg_div),
    .sck_in (sck_in),
    .tick   (tick)
  );

  sst_shifter #(.DATA_W(DATA_W), .NB_W(NB_W)) i_shift (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .load      (load),
    .ld_data   (hold),
    .ld_bits   (bits_dec),
    .tick      (tick),
    .busy      (busy),
    .frame_end (frame_end),
    .sdo       (sdo),
    .sck_out   (sck_out)
  );

  p_tde_after_load_r4: assert property (@(posedge clk) disable iff (rst)
    (load && !wr_ok) |=> flag_tde);

  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_end && load) |=> busy);

  p_tend_empty_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_tend) |-> flag_tde);

  p_ovr_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_ovr && !busy) |=> !busy);

endmodule

// File: tb/test_sync_ser_tx.sv
module test_sync_ser_tx;
  localparam int DW = 16, LW = 4, VW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_master = 1'b1, cfg_cpha = 1'b0, cfg_cpol = 1'b1;
  logic [LW-1:0] cfg_len = 4'd8;
  logic [VW-1:0] cfg_div = 8'd1;
  logic tx_en = 1'b1, ie_tde = 1'b0, ie_tend = 1'b0;
  logic wr_vld = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic clr_tend = 1'b0, ovr_set = 1'b0, clr_ovr = 1'b0, sck_in = 1'b1;
  logic sck_out, sck_oe, sdo, flag_tde, flag_tend, flag_ovr, irq_tde, irq_tend;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  longint cyc = 0;
  bit exp_q[$];
  bit mon_en = 0, mon_gap = 0;
  logic w_prev, prev_sdo;
  longint last_t = -1;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  sync_ser_tx i_sync_ser_tx (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_cpha(cfg_cpha),
    .cfg_cpol(cfg_cpol), .cfg_len(cfg_len), .cfg_div(cfg_div), .tx_en(tx_en),
    .ie_tde(ie_tde), .ie_tend(ie_tend), .wr_vld(wr_vld), .wr_data(wr_data),
    .clr_tend(clr_tend), .ovr_set(ovr_set), .clr_ovr(clr_ovr), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdo(sdo), .flag_tde(flag_tde),
    .flag_tend(flag_tend), .flag_ovr(flag_ovr), .irq_tde(irq_tde), .irq_tend(irq_tend)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected bit at every even clock transition.
  always @(negedge clk) begin
    logic w;
    w = cfg_master ? sck_out : sck_in;
    if (rst || !mon_en) begin
      w_prev = w;
      last_t = -1;
    end else if (w !== w_prev) begin
      if (mon_gap && cfg_master) begin
        if (last_t >= 0)
          check((cyc - last_t) == longint'(cfg_div) + 1, "R5 clock interval",
                cyc - last_t, longint'(cfg_div) + 1);
        last_t = cyc;
      end else begin
        last_t = -1;
      end
      if (w == cfg_cpol) begin
        if (exp_q.size() == 0) check(0, "R7 unexpected sampling edge", 1, 0);
        else begin
          bit e;
          e = exp_q.pop_front();
          check(prev_sdo == e, "R2 R8 serial bit", prev_sdo, e);
        end
      end
      w_prev = w;
    end
    prev_sdo = sdo;
  end

  task automatic send_word(input logic [DW-1:0] d, input int nbits);
    for (int i = 0; i < 5000 && !flag_tde; i++) @(negedge clk);
    wr_vld  = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_vld  = 1'b0;
    for (int i = 0; i < nbits; i++) exp_q.push_back(d[i]);
  endtask

  task automatic wait_tend(input string tag);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (flag_tend) break;
    end
    check(flag_tend == 1'b1, "R6 transmit end", flag_tend, 1);
    @(negedge clk);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    check(sck_out == cfg_cpol, "R7 clock at idle level", sck_out, cfg_cpol);
  endtask

  task automatic slave_clock(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      repeat (half) @(posedge clk);
      #1 sck_in = ~sck_in;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(flag_tde == 1, "R1 tde", flag_tde, 1);
    check(flag_tend == 0, "R1 tend", flag_tend, 0);
    check(flag_ovr == 0, "R1 ovr", flag_ovr, 0);
    check(sck_out == 1, "R1 sck idle", sck_out, 1);
    check(sdo == 0, "R1 sdo", sdo, 0);
    check(irq_tde == 0 && irq_tend == 0, "R1 irqs", {irq_tde, irq_tend}, 0);
    check(sck_oe == 1, "R7 oe master", sck_oe, 1);
    mon_en = 1;

    // R4 interrupt enable
    ie_tde = 1'b1;
    @(negedge clk);
    check(irq_tde == 1, "R4 irq_tde", irq_tde, 1);

    // R3 write ignored while disabled
    tx_en = 1'b0; wr_vld = 1'b1; wr_data = 16'h00A5;
    @(negedge clk);
    wr_vld = 1'b0;
    repeat (10) @(negedge clk);
    check(flag_tde == 1, "R3 ignored write keeps tde", flag_tde, 1);
    check(sck_out == 1, "R3 ignored write sends nothing", sck_out, 1);
    tx_en = 1'b1;

    // R2 R8 basic 8-bit master frame, cpha 0
    send_word(16'h00A5, 8);
    wait_tend("R2 frame A5 complete");
    check(irq_tend == 0, "R6 irq_tend masked", irq_tend, 0);
    ie_tend = 1'b1;
    @(negedge clk);
    check(irq_tend == 1, "R6 irq_tend", irq_tend, 1);
    clr_tend = 1'b1; @(negedge clk); clr_tend = 1'b0;
    check(flag_tend == 0, "R6 clr_tend", flag_tend, 0);

    // R5 back-to-back, gapless
    mon_gap = 1;
    send_word(16'h003C, 8);
    send_word(16'h00C3, 8);
    check(flag_tend == 0, "R6 no tend with word pending", flag_tend, 0);
    wait_tend("R5 back-to-back frames");
    mon_gap = 0;

    // R3 accepted write clears tend
    send_word(16'h0001, 8);
    check(flag_tend == 0, "R3 write clears tend", flag_tend, 0);
    wait_tend("R3 frame 01");

    // R2 lengths and R8 phase 1
    cfg_cpha = 1'b1; cfg_len = 4'd12;
    send_word(16'hFABC, 12);
    wait_tend("R2 12-bit cpha1");
    cfg_len = 4'd0;
    send_word(16'hBEEF, 16);
    wait_tend("R2 16-bit");
    cfg_cpha = 1'b0; cfg_len = 4'd3;
    send_word(16'h01F5, 8);
    wait_tend("R2 clamp code 3");
    cfg_len = 4'd8;

    // R7 idle level low, slower divider
    mon_en = 0; cfg_cpol = 1'b0; cfg_div = 8'd3;
    repeat (3) @(negedge clk);
    check(sck_out == 0, "R7 idle low", sck_out, 0);
    mon_en = 1;
    mon_gap = 1;
    send_word(16'h0096, 8);
    send_word(16'h0069, 8);
    wait_tend("R5 R7 cpol0 burst");
    mon_gap = 0;

    // R9 overrun blocks
    ovr_set = 1'b1; @(negedge clk); ovr_set = 1'b0;
    check(flag_ovr == 1, "R9 ovr set", flag_ovr, 1);
    send_word(16'h0055, 8);
    repeat (20) @(negedge clk);
    check(flag_tde == 0, "R9 word stays pending", flag_tde, 0);
    check(exp_q.size() == 8, "R9 nothing sent", exp_q.size(), 8);
    clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0;
    check(flag_ovr == 0, "R9 ovr cleared", flag_ovr, 0);
    wait_tend("R9 frame after clear");

    // R10 slave mode
    mon_en = 0; cfg_master = 1'b0; cfg_cpol = 1'b1; sck_in = 1'b1;
    repeat (5) @(negedge clk);
    check(sck_oe == 0, "R10 oe slave", sck_oe, 0);
    mon_en = 1;
    send_word(16'h0096, 8);
    repeat (4) @(negedge clk);
    slave_clock(16, 6);
    wait_tend("R10 slave cpha0");
    cfg_cpha = 1'b1;
    send_word(16'h004D, 8);
    repeat (4) @(negedge clk);
    slave_clock(16, 6);
    wait_tend("R10 slave cpha1");
    check(sck_out == 1, "R10 sck_out held", sck_out, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule